// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO with Command Capture

This block is the byte buffer that sits between a host register port and a storage-bus controller's data path. It serves programmed-I/O transfers and two-byte status/message responses. Each host write to the data port pushes one byte into a 16-entry circular buffer. Each host read request pops the oldest byte into a data register and raises a one-cycle interrupt pulse.

The block declares overrun when the buffer holds 15 bytes, which is one entry before it is truly full. Both pointers return to entry 0 whenever the occupancy drains to zero. A response load places a status byte and a zero byte at the start of the buffer.

While a command-capture mode is held high, host writes are steered into a separate 16-byte command buffer instead of the data FIFO. The capture length saturates at 16 rather than wrapping. The write side is a valid/ready stream whose ready is always high: the block never applies back-pressure, and a write that cannot be stored is dropped and reported on the overrun pulse. Reads are plain request pulses that carry no handshake.

Top module: `pio_fifo_ctl`

## Requirements
- R1: After reset, the byte count, FIFO flags, read data register, command length, interrupt and overrun are all zero, and wr_ready is 1.
- R2: A write with capture mode low, no response load and a count below 15 stores the byte at the write position and raises the count by one on the next cycle.
- R3: A write with capture mode low while the count equals 15 is dropped: the count and stored data are unchanged, and overrun pulses high for exactly the following cycle.
- R4: With capture mode high, each write stores its byte at command buffer index cmd_len and raises cmd_len by one. The FIFO count is unchanged, and the byte can be read back via cmd_rd_idx/cmd_rd_data.
- R5: cmd_len never exceeds 16, and writes are dropped once it reaches 16. cmd_clr sets cmd_len to 0 and takes priority over a write in the same cycle.
- R6: A read request with a nonzero count and phase_grp not equal to 2'b00 loads the oldest stored byte into rd_data on the next cycle (first-in first-out), lowers the count by one and pulses irq for one cycle.
- R7: A read request with a nonzero count and phase_grp equal to 2'b00 (data-out phase) loads 0x00 into rd_data, lowers the count and pulses irq, but consumes no stored byte: the next read in another phase returns the byte that would otherwise have been returned.
- R8: A read request with a count of zero leaves rd_data unchanged, leaves the count at zero and produces no irq.
- R9: Whenever the count becomes zero, both the read and write positions return to entry 0, so the next byte written is the next byte read.
- R10: A response load stores rsp_status at entry 0 and 0x00 at entry 1, sets the count to 2, resets both positions and sets fifo_flags to 2. A FIFO write or read in the same cycle is ignored.
- R11: A FIFO write and a read request in the same cycle, with the count between 1 and 14, both take effect and leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write of one byte to the data port |
| wr_ready | output | 1 | Always 1; writes are never back-pressured |
| wr_data | input | 8 | Byte being written |
| rd_req | input | 1 | Host read request (one pop per cycle held) |
| rd_data | output | 8 | Data register loaded by reads |
| phase_grp | input | 2 | Bus phase bits 2:1; 2'b00 means data-out |
| rsp_load | input | 1 | Load a two-byte response |
| rsp_status | input | 8 | Status byte for the response |
| cmd_mode | input | 1 | Steer writes into the command buffer |
| cmd_clr | input | 1 | Reset the command length to zero |
| cmd_rd_idx | input | 4 | Command buffer read index |
| cmd_rd_data | output | 8 | Command buffer byte at cmd_rd_idx |
| cmd_len | output | 5 | Number of captured command bytes |
| fifo_count | output | 5 | Bytes held in the data FIFO |
| fifo_flags | output | 8 | Flags register, loaded with 2 by a response load |
| overrun | output | 1 | One-cycle pulse for a dropped write |
| irq | output | 1 | One-cycle pulse per effective read |

## Verification
The hardest state to reach from the ports is a drained buffer whose read and write positions would disagree if they were not forced home. A read in the data-out phase lowers the count without advancing the read position. The stimulus therefore writes three bytes, spends one read in that phase, and drains the rest in a data-in phase. It then writes one more byte and checks that the same byte comes back. Overrun is reached by filling exactly 15 bytes, and the response load is issued while a write and a read are also asserted, so that its priority can be seen.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;
  typedef logic [7:0] byte_t;

  // Count of bytes loaded by a status/message response.
  localparam int RESP_BYTES = 2;

  // Phase bits 2:1 both low select the data-out phase.
  function automatic logic is_data_out(input logic [1:0] grp);
    return grp == 2'b00;
  endfunction
endpackage

// File: rtl/pio_byte_store.sv
module pio_byte_store
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  byte_t         wr_byte,
  input  logic          ld_en,
  input  byte_t         ld_byte,
  input  logic [AW-1:0] rd_idx,
  output byte_t         rd_byte
);
  logic [DEPTH*8-1:0] flat;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    byte_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (ld_en) begin
        if (i == 0)      q <= ld_byte;
        else if (i == 1) q <= '0;
      end else if (wr_en && wr_idx == AW'(i)) begin
        q <= wr_byte;
      end
    end
    assign flat[i*8 +: 8] = q;
  end

  assign rd_byte = flat[rd_idx*8 +: 8];
endmodule

// File: rtl/pio_fifo_track.sv
module pio_fifo_track
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          keep_rd_pos,
  input  logic          ld,
  output logic          wr_en,
  output logic [AW-1:0] wr_pos,
  output logic [AW-1:0] rd_pos,
  output logic          pop_fire,
  output logic [CW-1:0] cnt,
  output logic          irq_q,
  output logic          ovr_q
);
  localparam logic [CW-1:0] FULL_MARK = CW'(DEPTH - 1);
  localparam logic [CW-1:0] RESP_CNT  = CW'(RESP_BYTES);

  logic          push_ok, pop_ok;
  logic [CW-1:0] cnt_nx;
  logic [AW-1:0] rp_q, wp_q;

  assign push_ok  = push_req && !ld && (cnt != FULL_MARK);
  assign pop_ok   = pop_req && !ld && (cnt != '0);
  assign cnt_nx   = cnt + CW'(push_ok) - CW'(pop_ok);
  assign wr_en    = push_ok;
  assign wr_pos   = wp_q;
  assign rd_pos   = rp_q;
  assign pop_fire = pop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      rp_q  <= '0;
      wp_q  <= '0;
      irq_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      irq_q <= pop_ok;
      ovr_q <= push_req && !ld && (cnt == FULL_MARK);
      if (ld) begin
        cnt  <= RESP_CNT;
        rp_q <= '0;
        wp_q <= '0;
      end else begin
        cnt <= cnt_nx;
        if (cnt_nx == '0) begin
          rp_q <= '0;
          wp_q <= '0;
        end else begin
          if (pop_ok && !keep_rd_pos) rp_q <= rp_q + 1'b1;
          if (push_ok)                wp_q <= wp_q + 1'b1;
        end
      end
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_MARK);
  a_r9_ptrs_home: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (rp_q == '0 && wp_q == '0));
  a_r2_push_count: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && !ld && cnt < FULL_MARK) |=> cnt == CW'($past(cnt) + 1'b1));
  a_r3_overrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && !ld && cnt == FULL_MARK) |=> (ovr_q && cnt == FULL_MARK));
  a_r6_irq_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !ld && cnt != '0) |=> irq_q);
  a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && !ld && cnt == '0) |=> (!irq_q && cnt == '0));
  a_r10_load_count: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == RESP_CNT && rp_q == '0));
endmodule

// File: rtl/pio_cmd_capture.sv
module pio_cmd_capture
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  byte_t         wr_byte,
  input  logic          clr,
  input  logic [AW-1:0] rd_idx,
  output byte_t         rd_byte,
  output logic [LW-1:0] len
);
  localparam logic [LW-1:0] LIMIT = LW'(DEPTH);

  logic take;
  assign take = wr && !clr && (len != LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len <= '0;
    else if (clr)  len <= '0;
    else if (take) len <= len + 1'b1;
  end

  pio_byte_store #(.DEPTH(DEPTH), .AW(AW)) u_cbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (take),
    .wr_idx  (len[AW-1:0]),
    .wr_byte (wr_byte),
    .ld_en   (1'b0),
    .ld_byte ('0),
    .rd_idx  (rd_idx),
    .rd_byte (rd_byte)
  );

  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    len <= LIMIT);
  a_r4_capture_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr && len < LIMIT) |=> len == LW'($past(len) + 1'b1));
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> len == '0);
endmodule

// File: rtl/pio_fifo_ctl.sv
module pio_fifo_ctl
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 16,
  localparam int AW  = $clog2(DEPTH),
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int CAW = $clog2(CMD_DEPTH),
  localparam int CLW = $clog2(CMD_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic [7:0]     wr_data,
  input  logic           rd_req,
  output logic [7:0]     rd_data,
  input  logic [1:0]     phase_grp,
  input  logic           rsp_load,
  input  logic [7:0]     rsp_status,
  input  logic           cmd_mode,
  input  logic           cmd_clr,
  input  logic [CAW-1:0] cmd_rd_idx,
  output logic [7:0]     cmd_rd_data,
  output logic [CLW-1:0] cmd_len,
  output logic [CW-1:0]  fifo_count,
  output logic [7:0]     fifo_flags,
  output logic           overrun,
  output logic           irq
);
  logic          dout_phase;
  logic          st_wr_en, pop_fire;
  logic [AW-1:0] st_wr_pos, st_rd_pos;
  byte_t         st_rd_byte;
  byte_t         rd_q, flags_q;

  assign wr_ready   = 1'b1;
  assign dout_phase = is_data_out(phase_grp);

  pio_fifo_track #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_req    (wr_valid && !cmd_mode),
    .pop_req     (rd_req),
    .keep_rd_pos (dout_phase),
    .ld          (rsp_load),
    .wr_en       (st_wr_en),
    .wr_pos      (st_wr_pos),
    .rd_pos      (st_rd_pos),
    .pop_fire    (pop_fire),
    .cnt         (fifo_count),
    .irq_q       (irq),
    .ovr_q       (overrun)
  );

  pio_byte_store #(.DEPTH(DEPTH), .AW(AW)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (st_wr_en),
    .wr_idx  (st_wr_pos),
    .wr_byte (wr_data),
    .ld_en   (rsp_load),
    .ld_byte (rsp_status),
    .rd_idx  (st_rd_pos),
    .rd_byte (st_rd_byte)
  );

  pio_cmd_capture #(.DEPTH(CMD_DEPTH), .AW(CAW), .LW(CLW)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_valid && cmd_mode),
    .wr_byte (wr_data),
    .clr     (cmd_clr),
    .rd_idx  (cmd_rd_idx),
    .rd_byte (cmd_rd_data),
    .len     (cmd_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= '0;
      flags_q <= '0;
    end else begin
      if (pop_fire) rd_q <= dout_phase ? '0 : st_rd_byte;
      if (rsp_load) flags_q <= 8'(RESP_BYTES);
    end
  end

  assign rd_data    = rd_q;
  assign fifo_flags = flags_q;

  a_r7_dataout_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rsp_load && fifo_count != '0 && phase_grp == 2'b00) |=> rd_data == 8'h00);
  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rsp_load && fifo_count == '0) |=> $stable(rd_data));
  a_r4_fifo_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mode && !rd_req && !rsp_load) |=> $stable(fifo_count));
endmodule

// File: tb/sim_pio_fifo_ctl.sv
`timescale 1ns/1ps
module sim_pio_fifo_ctl;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_valid = 0, rd_req = 0, rsp_load = 0, cmd_mode = 0, cmd_clr = 0;
  logic [7:0] wr_data = 0, rsp_status = 0;
  logic [1:0] phase_grp = 2'b01;
  logic [3:0] cmd_rd_idx = 0;
  logic       wr_ready, overrun, irq;
  logic [7:0] rd_data, cmd_rd_data, fifo_flags;
  logic [4:0] cmd_len, fifo_count;

  int checks = 0, failures = 0;
  int mem[16];
  int cbuf[16];
  int rp = 0, wp = 0, cnt = 0, rdq = 0, eirq = 0, eovr = 0, eflags = 0, clen = 0;

  always #2.5 clk = ~clk;

  pio_fifo_ctl u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data), .phase_grp(phase_grp),
    .rsp_load(rsp_load), .rsp_status(rsp_status), .cmd_mode(cmd_mode),
    .cmd_clr(cmd_clr), .cmd_rd_idx(cmd_rd_idx), .cmd_rd_data(cmd_rd_data),
    .cmd_len(cmd_len), .fifo_count(fifo_count), .fifo_flags(fifo_flags),
    .overrun(overrun), .irq(irq)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "fifo_count", fifo_count, cnt);
    chk(tag, "rd_data", rd_data, rdq);
    chk(tag, "irq", irq, eirq);
    chk(tag, "overrun", overrun, eovr);
    chk(tag, "fifo_flags", fifo_flags, eflags);
    chk(tag, "cmd_len", cmd_len, clen);
    chk(tag, "wr_ready", wr_ready, 1);
  endtask

  // Reference model step, applied with the inputs in force before the edge.
  task automatic model_step();
    bit push, pop, dout;
    dout = (phase_grp == 2'b00);
    if (cmd_clr) clen = 0;
    else if (cmd_mode && wr_valid && clen < 16) begin
      cbuf[clen] = wr_data;
      clen++;
    end
    if (rsp_load) begin
      mem[0] = rsp_status; mem[1] = 0;
      cnt = 2; rp = 0; wp = 0; eflags = 2; eirq = 0; eovr = 0;
    end else begin
      push = wr_valid && !cmd_mode && cnt != 15;
      eovr = wr_valid && !cmd_mode && cnt == 15;
      pop  = rd_req && cnt > 0;
      eirq = pop;
      if (pop) begin
        rdq = dout ? 0 : mem[rp];
        if (!dout) rp = (rp + 1) % 16;
      end
      if (push) begin
        mem[wp] = wr_data;
        wp = (wp + 1) % 16;
      end
      cnt = cnt + int'(push) - int'(pop);
      if (cnt == 0) begin rp = 0; wp = 0; end
    end
  endtask

  task automatic cyc(input string tag, input bit wv, input int wd, input bit rr,
                     input logic [1:0] ph, input bit ld, input int st,
                     input bit cm, input bit cc);
    wr_valid = wv; wr_data = 8'(wd); rd_req = rr; phase_grp = ph;
    rsp_load = ld; rsp_status = 8'(st); cmd_mode = cm; cmd_clr = cc;
    @(posedge clk);
    model_step();
    #1;
    compare_all(tag);
    @(negedge clk);
    wr_valid = 0; rd_req = 0; rsp_load = 0; cmd_clr = 0;
  endtask

  task automatic wr(input string tag, input int d);
    cyc(tag, 1, d, 0, 2'b01, 0, 0, 0, 0);
  endtask

  task automatic rd(input string tag, input logic [1:0] ph);
    cyc(tag, 0, 0, 1, ph, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mem[i] = 0; cbuf[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    compare_all("R1");
    rst_n = 1;
    @(negedge clk);
    compare_all("R1");

    // R2 / R6: push three bytes, pop in order
    wr("R2", 8'h11); wr("R2", 8'h22); wr("R2", 8'h33);
    rd("R6", 2'b01);
    // R11: concurrent write and read
    cyc("R11", 1, 8'h44, 1, 2'b11, 0, 0, 0, 0);
    rd("R6", 2'b01); rd("R6", 2'b01);
    // R8: read at empty
    rd("R8", 2'b01); rd("R8", 2'b10);

    // R7 / R9: data-out read consumes no byte, drain resets pointers
    wr("R7", 8'hA1); wr("R7", 8'hA2); wr("R7", 8'hA3);
    rd("R7", 2'b00);
    rd("R7", 2'b01);
    rd("R9", 2'b01);
    wr("R9", 8'hB1);
    rd("R9", 2'b01);

    // R3: fill to 15, then overrun
    for (int i = 0; i < 15; i++) wr("R2", 8'h50 + i);
    wr("R3", 8'hEE);
    wr("R3", 8'hEF);
    cyc("R3", 0, 0, 0, 2'b01, 0, 0, 0, 0);
    for (int i = 0; i < 15; i++) rd("R3", 2'b11);

    // R4 / R5: command capture with saturation
    for (int i = 0; i < 18; i++) cyc("R4", 1, 8'hC0 + i, 0, 2'b01, 0, 0, 1, 0);
    for (int i = 0; i < 16; i++) begin
      cmd_rd_idx = 4'(i);
      #1;
      chk("R4", "cmd_rd_data", cmd_rd_data, cbuf[i]);
    end
    cyc("R5", 1, 8'h99, 0, 2'b01, 0, 0, 1, 1);
    cyc("R5", 1, 8'h9A, 0, 2'b01, 0, 0, 1, 0);
    cmd_rd_idx = 0;
    #1;
    chk("R5", "cmd_rd_data", cmd_rd_data, 8'h9A);
    cmd_mode = 0;

    // R10: response load wins over concurrent write and read
    wr("R10", 8'h71); wr("R10", 8'h72); wr("R10", 8'h73);
    cyc("R10", 1, 8'h74, 1, 2'b01, 1, 8'h5A, 0, 0);
    rd("R10", 2'b01);
    rd("R10", 2'b01);
    rd("R10", 2'b01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule